// File: doc/BRIEF.md
# Serial EEPROM Slave Command Engine

This block is the slave-side control logic of a 256-word by 8-bit serial nonvolatile memory, with the storage held in a register array. A host selects the block by pulling an active-low select line. It then clocks in a frame on a serial clock: an address field, a 4-bit command code and, for a write, a data byte. The block decodes the frame. It can return one byte or a wrapping stream of bytes, write one byte, clear the whole array, report a live ready/busy flag, or set or clear a write-permission latch.

Writes and full clears are timed. A down-counter of configurable length stands in for the internal programming timer. The host may release the select line while that timer runs. Until the timer expires, every command except the status query is refused. All serial pins are sampled on a fast system clock, and serial clock edges are recovered from those samples.

Top module: `serial_nvm_slave`

## Requirements
- R1: While `cs_ni` is high, serial clock edges are ignored and `sdo_o` stays high.
- R2: A frame carries 8 address bits, then 4 command bits, then (for a write) 8 data bits. Each field is sent LSB first, and a bit is taken on each rising serial clock edge. Command codes: read 0x1, write 0x2, streaming read 0x3, erase-all 0x4, status 0x5, unlock 0x6, lock 0x7.
- R3: A read (0x1) presents the addressed byte on `sdo_o` LSB first. Each bit appears on one falling serial clock edge, starting with the first falling edge after the command field. On the falling edge after the eighth bit, `sdo_o` returns high.
- R4: A streaming read (0x3) keeps going after each byte with the next address, and the address wraps from 0xFF to 0x00.
- R5: An accepted write stores its data byte when the timer expires. The timer keeps running after `cs_ni` is raised.
- R6: An accepted erase-all sets every location to 0x00.
- R7: After a status command (0x5), `sdo_o` shows 0 while a timed operation runs and 1 otherwise, and follows the flag live until `cs_ni` rises.
- R8: While a timed operation runs, every command other than status is refused with no effect, including lock and unlock.
- R9: Write and erase-all take effect only while the permission latch is set. The latch is cleared at reset, cleared by lock and set by unlock.
- R10: A frame with any command code outside the listed set has no effect.
- R11: `rst_ni` low aborts any partial frame and any running timed operation and clears the permission latch. Stored data is left unchanged.
- R12: The busy state lasts exactly `PROG_CYCLES` system clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; all serial pins are sampled on it |
| rst_ni | input | 1 | Asynchronous active-low reset of the control logic |
| cs_ni | input | 1 | Active-low chip select |
| sck_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data in, taken on rising serial clock edges |
| sdo_o | output | 1 | Serial data out, updated on falling serial clock edges |

## Verification
The bench attacks the busy window first. It issues a read, a write and a lock while a write is still timing. A design that failed to gate on busy would drive data, corrupt a second location, or drop write permission. It then times the status flag against the programmed length, which exposes an off-by-one timer. The streaming read is started two bytes below the top of the address space, so a design that stops, saturates or skips at the wrap returns the wrong third and fourth bytes. Reset is pulsed in the middle of a timed write and in the middle of a frame. A design that commits on abort, leaves permission set, or keeps stale bit counts shows wrong data on the next reads.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

  localparam int CMD_W = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_READ        = 4'h1,
    CMD_WRITE       = 4'h2,
    CMD_READ_STREAM = 4'h3,
    CMD_ERASE_ALL   = 4'h4,
    CMD_STATUS      = 4'h5,
    CMD_UNLOCK      = 4'h6,
    CMD_LOCK        = 4'h7
  } cmd_e;

  typedef enum logic [1:0] {
    JOB_NONE  = 2'd0,
    JOB_WRITE = 2'd1,
    JOB_ERASE = 2'd2
  } job_e;

  function automatic logic is_read_cmd(input logic [CMD_W-1:0] c);
    return (c == CMD_READ) || (c == CMD_READ_STREAM);
  endfunction

  function automatic logic is_status_cmd(input logic [CMD_W-1:0] c);
    return c == CMD_STATUS;
  endfunction

endpackage

// File: rtl/nvm_pin_sync.sv
module nvm_pin_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic sdi_i,
  output logic sel_o,
  output logic rise_o,
  output logic fall_o,
  output logic sdi_o
);
  logic cs_q, sck_q, sck_prev_q, sdi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q       <= 1'b1;
      sck_q      <= 1'b0;
      sck_prev_q <= 1'b0;
      sdi_q      <= 1'b0;
    end else begin
      cs_q       <= cs_ni;
      sck_q      <= sck_i;
      sck_prev_q <= sck_q;
      sdi_q      <= sdi_i;
    end
  end

  assign sel_o  = ~cs_q;
  assign rise_o = sel_o & sck_q & ~sck_prev_q;
  assign fall_o = sel_o & ~sck_q & sck_prev_q;
  assign sdi_o  = sdi_q;

endmodule

// File: rtl/nvm_frame_rx.sv
module nvm_frame_rx #(
  parameter int ADDR_W = 8,
  parameter int CMD_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              rise_i,
  input  logic              sdi_i,
  output logic              hdr_stb_o,
  output logic              dat_stb_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int HDR_LEN  = ADDR_W + CMD_W;
  localparam int FULL_LEN = HDR_LEN + DATA_W;
  localparam int CNT_W    = $clog2(FULL_LEN + 1);

  logic [FULL_LEN-1:0] bits_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                take_bit;

  assign take_bit = rise_i && (cnt_q != CNT_W'(FULL_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q    <= '0;
      cnt_q     <= '0;
      hdr_stb_o <= 1'b0;
      dat_stb_o <= 1'b0;
    end else begin
      hdr_stb_o <= 1'b0;
      dat_stb_o <= 1'b0;
      if (!sel_i) begin
        cnt_q <= '0;
      end else if (take_bit) begin
        bits_q[cnt_q] <= sdi_i;
        cnt_q         <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(HDR_LEN - 1))  hdr_stb_o <= 1'b1;
        if (cnt_q == CNT_W'(FULL_LEN - 1)) dat_stb_o <= 1'b1;
      end
    end
  end

  assign addr_o = bits_q[ADDR_W-1:0];
  assign cmd_o  = bits_q[HDR_LEN-1:ADDR_W];
  assign data_o = bits_q[FULL_LEN-1:HDR_LEN];

  // R2: header and data strobes belong to different bit positions of one frame
  assert_strobes_apart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_stb_o |-> !dat_stb_o);

endmodule

// File: rtl/nvm_busy_timer.sv
module nvm_busy_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] left_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
    end else if (start_i) begin
      left_q <= CW'(CYCLES);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign busy_o = (left_q != '0);
  assign done_o = (left_q == CW'(1));

  // checker-side run-length counter for the timing window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (!busy_o) run_q <= '0;
    else              run_q <= run_q + 1'b1;
  end

  assert_busy_len_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == CW'(CYCLES)));

  assert_no_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);

endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wa_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] ra_i,
  output logic [DATA_W-1:0] rd_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (clr_i)                              cells[i] <= '0;
      else if (we_i && wa_i == ADDR_W'(i))    cells[i] <= wd_i;
    end
  end

  assign rd_o = cells[ra_i];

  // R6: a clear and a single-word write never commit together
  assert_clear_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && clr_i));

endmodule

// File: rtl/serial_nvm_slave.sv
module serial_nvm_slave
  import nvm_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic sdi_i,
  output logic sdo_o
);
  localparam int RC_W  = $clog2(DATA_W + 1);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  // pin front end
  logic sel, rise, fall, sdi_s;
  nvm_pin_sync u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck_i), .sdi_i(sdi_i),
    .sel_o(sel), .rise_o(rise), .fall_o(fall), .sdi_o(sdi_s)
  );

  // frame assembly
  logic              hdr_stb, dat_stb;
  logic [ADDR_W-1:0] f_addr;
  logic [CMD_W-1:0]  f_cmd;
  logic [DATA_W-1:0] f_data;
  nvm_frame_rx #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .DATA_W(DATA_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel), .rise_i(rise), .sdi_i(sdi_s),
    .hdr_stb_o(hdr_stb), .dat_stb_o(dat_stb),
    .addr_o(f_addr), .cmd_o(f_cmd), .data_o(f_data)
  );

  // control state
  logic              wen_q, mon_q, rd_on_q, rd_stream_q, wr_wait_q, sdo_q;
  logic [RC_W-1:0]   rd_cnt_q;
  logic [ADDR_W-1:0] rd_addr_q, job_addr_q;
  logic [DATA_W-1:0] job_data_q;
  job_e              job_q;

  // named internal events
  logic busy, tmr_done;
  logic accept_hdr, take_cmd, start_erase, start_write, tmr_start;
  logic byte_done, cell_we, cell_clr;
  logic [ADDR_W-1:0] rd_ra;
  logic [DATA_W-1:0] rd_word;

  assign accept_hdr  = hdr_stb && sel;
  assign take_cmd    = accept_hdr && !busy && !is_status_cmd(f_cmd);
  assign start_erase = take_cmd && (f_cmd == CMD_ERASE_ALL) && wen_q;
  assign start_write = dat_stb && sel && wr_wait_q && wen_q && !busy;
  assign tmr_start   = start_erase || start_write;
  assign byte_done   = (rd_cnt_q == RC_W'(DATA_W));
  assign rd_ra       = byte_done ? addr_step(rd_addr_q) : rd_addr_q;
  assign cell_we     = tmr_done && (job_q == JOB_WRITE);
  assign cell_clr    = tmr_done && (job_q == JOB_ERASE);

  nvm_busy_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(tmr_start),
    .busy_o(busy), .done_o(tmr_done)
  );

  nvm_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cells (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cell_we), .wa_i(job_addr_q), .wd_i(job_data_q),
    .clr_i(cell_clr), .ra_i(rd_ra), .rd_o(rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_q       <= 1'b0;
      mon_q       <= 1'b0;
      rd_on_q     <= 1'b0;
      rd_stream_q <= 1'b0;
      rd_cnt_q    <= '0;
      rd_addr_q   <= '0;
      wr_wait_q   <= 1'b0;
      job_q       <= JOB_NONE;
      job_addr_q  <= '0;
      job_data_q  <= '0;
      sdo_q       <= 1'b1;
    end else begin
      if (tmr_done) job_q <= JOB_NONE;
      if (start_erase) job_q <= JOB_ERASE;
      if (start_write) begin
        job_q      <= JOB_WRITE;
        job_addr_q <= f_addr;
        job_data_q <= f_data;
      end

      if (!sel) begin
        mon_q     <= 1'b0;
        rd_on_q   <= 1'b0;
        wr_wait_q <= 1'b0;
        sdo_q     <= 1'b1;
      end else begin
        if (accept_hdr && is_status_cmd(f_cmd)) mon_q <= 1'b1;
        if (take_cmd) begin
          case (cmd_e'(f_cmd))
            CMD_UNLOCK: wen_q     <= 1'b1;
            CMD_LOCK:   wen_q     <= 1'b0;
            CMD_WRITE:  wr_wait_q <= 1'b1;
            CMD_READ, CMD_READ_STREAM: begin
              rd_on_q     <= 1'b1;
              rd_stream_q <= (f_cmd == CMD_READ_STREAM);
              rd_cnt_q    <= '0;
              rd_addr_q   <= f_addr;
            end
            default: ;
          endcase
        end
        if (dat_stb) wr_wait_q <= 1'b0;
        if (fall && rd_on_q) begin
          if (byte_done) begin
            if (rd_stream_q) begin
              rd_addr_q <= rd_ra;
              sdo_q     <= rd_word[0];
              rd_cnt_q  <= RC_W'(1);
            end else begin
              rd_on_q <= 1'b0;
              sdo_q   <= 1'b1;
            end
          end else begin
            sdo_q    <= rd_word[rd_cnt_q[BIT_W-1:0]];
            rd_cnt_q <= rd_cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign sdo_o = mon_q ? ~busy : sdo_q;

  assert_idle_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel |=> sdo_o);

  assert_start_enabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(wen_q));

  assert_commit_pending_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> $past(job_q != JOB_NONE));

  assert_read_not_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_on_q) |-> !$past(busy));

  assert_reset_locked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !wen_q);

endmodule

// File: tb/serial_nvm_slave_tb.sv
module serial_nvm_slave_tb_top;
  localparam int PROG_T = 1000;
  localparam int H      = 4;
  localparam int C_RD = 1, C_WR = 2, C_RS = 3, C_ER = 4, C_ST = 5, C_EN = 6, C_DIS = 7;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo;

  always #5 clk = ~clk;

  serial_nvm_slave #(.PROG_CYCLES(PROG_T)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi), .sdo_o(sdo)
  );

  int n_chk = 0, n_err = 0, cyc = 0, rise_cyc = 0, hi_cnt = 0;
  int mem_m [256];
  bit wen_m = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-clock model: deselected line must idle high
  always @(negedge clk) begin
    if (rst_n && cs_n) begin
      hi_cnt++;
      if (hi_cnt > 3) check(sdo === 1'b1, "R1", "idle output", int'(sdo), 1);
    end else hi_cnt = 0;
  end

  task automatic halfp(); repeat (H) @(negedge clk); endtask
  task automatic open_t(); @(negedge clk); cs_n = 1'b0; halfp(); endtask
  task automatic close_t(); @(negedge clk); sck = 1'b0; halfp(); cs_n = 1'b1; halfp(); halfp(); endtask

  task automatic put_bit(input bit b);
    @(negedge clk); sck = 1'b0; sdi = b; halfp(); sck = 1'b1; rise_cyc = cyc; halfp();
  endtask

  task automatic put_field(input int v, input int n);
    for (int i = 0; i < n; i++) put_bit(v[i]);
  endtask

  task automatic get_bit(output bit b);
    @(negedge clk); sck = 1'b0; halfp(); b = sdo; sck = 1'b1; halfp();
  endtask

  task automatic get_byte(output int v);
    v = 0;
    for (int i = 0; i < 8; i++) begin
      bit b;
      get_bit(b);
      v[i] = b;
    end
  endtask

  task automatic frame(input int a, input int c); put_field(a, 8); put_field(c, 4); endtask

  task automatic simple(input int c);
    open_t(); frame(0, c); close_t();
    if (c == C_EN) wen_m = 1'b1;
    if (c == C_DIS) wen_m = 1'b0;
  endtask

  task automatic prog(input int a, input int d);
    open_t(); frame(a, C_WR); put_field(d, 8); close_t();
    if (wen_m) mem_m[a] = d;
  endtask

  task automatic erase();
    open_t(); frame(0, C_ER); close_t();
    if (wen_m) for (int i = 0; i < 256; i++) mem_m[i] = 0;
  endtask

  task automatic wait_ready(output int t_rdy, input bit busy_first, input string req);
    open_t(); frame(0, C_ST);
    @(negedge clk);
    check(sdo === !busy_first, req, "status flag at start", int'(sdo), int'(!busy_first));
    t_rdy = -1;
    for (int k = 0; k < 2 * PROG_T; k++) begin
      if (sdo === 1'b1) begin t_rdy = cyc; break; end
      @(negedge clk);
    end
    check(t_rdy >= 0, req, "ready flag seen", t_rdy, 0);
    close_t();
  endtask

  task automatic read_chk(input int a, input bit stream, input int nbytes, input string req);
    int v;
    bit b;
    open_t(); frame(a, stream ? C_RS : C_RD);
    for (int k = 0; k < nbytes; k++) begin
      get_byte(v);
      check(v == mem_m[(a + k) % 256], req, "read byte", v, mem_m[(a + k) % 256]);
    end
    if (!stream) begin
      get_bit(b);
      check(b == 1'b1, req, "line high after byte", int'(b), 1);
    end
    close_t();
  endtask

  initial begin
    int t, t0, t1;
    bit b;
    for (int i = 0; i < 256; i++) mem_m[i] = 0;
    repeat (3) @(negedge clk);
    check(sdo === 1'b1, "R11", "output during reset", int'(sdo), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9: power-up locked, erase refused (no busy)
    erase();
    wait_ready(t, 1'b0, "R9");
    // R6: unlock and clear everything
    simple(C_EN);
    erase();
    wait_ready(t, 1'b1, "R6");
    read_chk(8'h00, 1'b0, 1, "R6");
    read_chk(8'hFF, 1'b0, 1, "R6");
    read_chk(8'h5A, 1'b1, 3, "R6");

    // R5/R8/R12: timed write, then refused commands while busy
    prog(8'h10, 8'h3C);
    t0 = rise_cyc;
    open_t(); frame(8'h10, C_RD);
    for (int k = 0; k < 8; k++) begin
      get_bit(b);
      check(b == 1'b1, "R8", "read refused while busy", int'(b), 1);
    end
    close_t();
    open_t(); frame(8'h11, C_WR); put_field(8'hEE, 8); close_t();
    open_t(); frame(0, C_DIS); close_t();
    wait_ready(t1, 1'b1, "R7");
    check((t1 - t0) >= PROG_T && (t1 - t0) <= PROG_T + 8, "R12", "busy duration", t1 - t0, PROG_T + 3);
    read_chk(8'h10, 1'b0, 1, "R5");
    read_chk(8'h11, 1'b0, 1, "R8");
    prog(8'h31, 8'h11);
    wait_ready(t, 1'b1, "R8");
    read_chk(8'h31, 1'b0, 1, "R8");

    // R2: bit order of address field
    prog(8'h01, 8'hC3);
    wait_ready(t, 1'b1, "R2");
    read_chk(8'h80, 1'b0, 1, "R2");
    read_chk(8'h01, 1'b0, 1, "R2");

    // R4: streaming read across the wrap
    prog(8'hFF, 8'h81);
    wait_ready(t, 1'b1, "R4");
    prog(8'h00, 8'h7E);
    wait_ready(t, 1'b1, "R4");
    read_chk(8'hFE, 1'b1, 4, "R4");
    read_chk(8'hFF, 1'b0, 1, "R3");

    // R10: unknown command codes
    open_t(); frame(8'h10, 4'hF); put_field(8'h00, 8); close_t();
    open_t(); frame(8'h10, 4'h0); put_field(8'h00, 8); close_t();
    wait_ready(t, 1'b0, "R10");
    read_chk(8'h10, 1'b0, 1, "R10");

    // R9: locked writes and erase are refused
    simple(C_DIS);
    prog(8'h40, 8'hAA);
    wait_ready(t, 1'b0, "R9");
    read_chk(8'h40, 1'b0, 1, "R9");
    erase();
    read_chk(8'h10, 1'b0, 1, "R9");

    // R11: reset mid-write aborts and relocks
    simple(C_EN);
    open_t(); frame(8'h50, C_WR); put_field(8'h55, 8); close_t();
    repeat (20) @(negedge clk);
    rst_n = 1'b0; wen_m = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    wait_ready(t, 1'b0, "R11");
    read_chk(8'h50, 1'b0, 1, "R11");
    read_chk(8'h10, 1'b0, 1, "R11");
    prog(8'h51, 8'h66);
    read_chk(8'h51, 1'b0, 1, "R9");

    // R11: reset in the middle of a frame
    open_t(); put_field(8'h10, 6);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    sck = 1'b0; cs_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    read_chk(8'h10, 1'b0, 1, "R11");

    // R1: clock activity while deselected is ignored
    @(negedge clk); sdi = 1'b1;
    for (int k = 0; k < 20; k++) begin
      sck = 1'b1; halfp(); sck = 1'b0; halfp();
    end
    read_chk(8'h10, 1'b0, 1, "R1");

    // R6: final clear
    simple(C_EN);
    erase();
    wait_ready(t, 1'b1, "R6");
    read_chk(8'h10, 1'b0, 1, "R6");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule